// File: doc/BRIEF.md
# CPU Cycle Arbiter and Step Counter

This block is the master controller of a small sequenced processor. It decides which of four machine states is current (halted, servicing an interrupt, fetching an instruction or executing one) and publishes that choice as a 2-bit status code. The combinational sequencers elsewhere in the core decode this code so that exactly one of them is active.

Alongside the state, the block keeps a step counter. Its low three bits name the step within the running sequence, with count 0 standing for the first step and count 7 for the eighth. The active sequencer watches the count, drives its control signals for each step, and pulls an active-low end-of-sequence strobe when it finishes. In response, the arbiter chooses the next state and restarts the count. The machine loops from fetch to execute, and then either back to fetch or into an interrupt entry sequence. At the end of every execute sequence the arbiter checks a fail condition, which can send the machine to halt instead.

Top module: `cycle_arbiter`

## Requirements
- R1: While reset is high, and after it is released, the status code is 00 (Halt), the step count is 0 and the step-clear flag is 1.
- R2: In Halt (00), the state stays Halt while run_i is low. A clock edge with run_i high moves the state to Fetch (10).
- R3: run_i has no effect outside Halt. end_n_i has no effect in Halt.
- R4: In Fetch (10), a clock edge with end_n_i low moves the state to Exec (11).
- R5: In Exec (11), a clock edge with end_n_i low and fail_i low moves the state to Interrupt (01) when irq_req_i and irq_en_i are both high. Otherwise it moves the state to Fetch (10).
- R6: In Interrupt (01), a clock edge with end_n_i low moves the state to Fetch (10).
- R7: In Exec (11), a clock edge with end_n_i low and fail_i high moves the state to Halt (00) when halt_on_fail_i is high, and to Fetch (10) otherwise. This takes priority over an interrupt request. fail_i is ignored at every other point.
- R8: The step count reads 0 in the first cycle after any state change and throughout Halt. While a non-Halt state holds, the count rises by one per clock and saturates at all ones (15 for the default width).
- R9: step_clr_o is 1 in every cycle whose step count was loaded with zero at the previous edge, because of a state change or because the state was Halt. It is 0 in every other cycle.
- R10: Outside Halt, the state does not change while end_n_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Start request from the console |
| end_n_i | input | 1 | End-of-sequence strobe, active low |
| irq_req_i | input | 1 | Interrupt request pending |
| irq_en_i | input | 1 | Interrupts enabled |
| fail_i | input | 1 | Fail condition present |
| halt_on_fail_i | input | 1 | Halt-on-fail switch |
| status_o | output | 2 | Machine state: 00 Halt, 01 Interrupt, 10 Fetch, 11 Exec |
| step_o | output | STEP_W | Step count within the current sequence |
| step_clr_o | output | 1 | Step count was cleared at the last edge |

## Verification
The assertions assume that every input is a clean synchronous level that holds steady across the sampling edge. They also assume that the end-of-sequence strobe may appear in any state and at any step count, including the case where it coincides with fail and interrupt inputs. The stimulus changes inputs only on the falling clock edge. It steers the design into each of the four states and applies all 64 combinations of the six control inputs there. A long run in one state carries the step count past 8 and into saturation.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_HALT  = 2'b00,
    ST_INTR  = 2'b01,
    ST_FETCH = 2'b10,
    ST_EXEC  = 2'b11
  } arb_state_e;

endpackage

// File: rtl/arb_state_fsm.sv
module arb_state_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       end_n,
  input  logic       irq_req,
  input  logic       irq_en,
  input  logic       fail,
  input  logic       hof,
  output arb_state_e state_q,
  output logic       restart
);

  arb_state_e nxt;
  logic       done;

  assign done = ~end_n;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_HALT:  if (run)  nxt = ST_FETCH;
      ST_FETCH: if (done) nxt = ST_EXEC;
      ST_EXEC: begin
        if (done) begin
          if (fail)                  nxt = hof ? ST_HALT : ST_FETCH;
          else if (irq_req && irq_en) nxt = ST_INTR;
          else                       nxt = ST_FETCH;
        end
      end
      ST_INTR:  if (done) nxt = ST_FETCH;
      default:  nxt = ST_HALT;
    endcase
  end

  // The step count restarts on any state change and is held at zero in Halt.
  assign restart = (nxt != state_q) || (state_q == ST_HALT);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_HALT;
    else     state_q <= nxt;
  end

  a_r2_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && !run) |=> state_q == ST_HALT);

  a_r4_fetch_exec: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH && !end_n) |=> state_q == ST_EXEC);

  a_r6_intr_fetch: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_INTR && !end_n) |=> state_q == ST_FETCH);

  a_r7_halt_on_fail: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && !end_n && fail && hof) |=> state_q == ST_HALT);

  a_r10_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_HALT && end_n) |=> $stable(state_q));

endmodule

// File: rtl/arb_step_ctr.sv
module arb_step_ctr #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [STEP_W-1:0] cnt_q,
  output logic              clr_q
);

  localparam logic [STEP_W-1:0] CNT_MAX = {STEP_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      clr_q <= 1'b1;
    end else if (restart) begin
      cnt_q <= '0;
      clr_q <= 1'b1;
    end else begin
      clr_q <= 1'b0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt_q == '0);

  a_r8_count_up: assert property (@(posedge clk) disable iff (rst)
    (!restart && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (!restart && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  a_r9_clear_flag: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> cnt_q == '0);

endmodule

// File: rtl/cycle_arbiter.sv
module cycle_arbiter #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              end_n_i,
  input  logic              irq_req_i,
  input  logic              irq_en_i,
  input  logic              fail_i,
  input  logic              halt_on_fail_i,
  output logic [1:0]        status_o,
  output logic [STEP_W-1:0] step_o,
  output logic              step_clr_o
);

  arb_pkg::arb_state_e state_q;
  logic                restart;

  arb_state_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .run     (run_i),
    .end_n   (end_n_i),
    .irq_req (irq_req_i),
    .irq_en  (irq_en_i),
    .fail    (fail_i),
    .hof     (halt_on_fail_i),
    .state_q (state_q),
    .restart (restart)
  );

  arb_step_ctr #(.STEP_W(STEP_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .cnt_q   (step_o),
    .clr_q   (step_clr_o)
  );

  assign status_o = state_q;

endmodule

// File: tb/cycle_arbiter_test.sv
module cycle_arbiter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0, end_n = 1'b1, irq = 1'b0, ien = 1'b0, fail = 1'b0, hof = 1'b0;
  logic [1:0] status;
  logic [3:0] step;
  logic       sclr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [1:0] m_st;
  logic [3:0] m_step;
  logic       m_clr;

  always #4 clk = ~clk;

  cycle_arbiter #(.STEP_W(4)) uut (
    .clk(clk), .rst(rst), .run_i(run), .end_n_i(end_n), .irq_req_i(irq),
    .irq_en_i(ien), .fail_i(fail), .halt_on_fail_i(hof),
    .status_o(status), .step_o(step), .step_clr_o(sclr)
  );

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, status, m_st, "status");
    check("R8", step, m_step, "step");
    check("R9", sclr, m_clr, "step_clr");
  endtask

  task automatic do_reset();
    rst = 1'b1; run = 0; end_n = 1; irq = 0; ien = 0; fail = 0; hof = 0;
    @(posedge clk); @(negedge clk);
    m_st = 2'b00; m_step = 0; m_clr = 1;
    compare("R1");
    rst = 1'b0;
  endtask

  // Called at a falling edge; drives inputs, waits one rising edge, checks.
  task automatic tick(input logic r, input logic e, input logic q,
                      input logic en, input logic f, input logic h);
    logic [1:0] ns;
    string tag;
    run = r; end_n = e; irq = q; ien = en; fail = f; hof = h;
    ns = m_st;
    case (m_st)
      2'b00: begin ns = r ? 2'b10 : 2'b00; tag = r ? "R2" : "R3"; end
      2'b10: begin ns = !e ? 2'b11 : 2'b10; tag = !e ? "R4" : (r ? "R3" : "R10"); end
      2'b11: begin
        if (!e) begin
          if (f) begin ns = h ? 2'b00 : 2'b10; tag = "R7"; end
          else   begin ns = (q && en) ? 2'b01 : 2'b10; tag = "R5"; end
        end else tag = (r ? "R3" : "R10");
      end
      default: begin ns = !e ? 2'b10 : 2'b01; tag = !e ? "R6" : (r ? "R3" : "R10"); end
    endcase
    @(posedge clk);
    if (ns != m_st || m_st == 2'b00) begin m_step = 0; m_clr = 1; end
    else begin m_clr = 0; if (m_step != 4'hF) m_step = m_step + 1; end
    m_st = ns;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic goto_state(input int s);
    do_reset();
    if (s == 0) return;
    tick(1, 1, 0, 0, 0, 0);             // Halt -> Fetch
    if (s == 2) return;
    tick(0, 0, 0, 0, 0, 0);             // Fetch -> Exec
    if (s == 3) return;
    tick(0, 0, 1, 1, 0, 0);             // Exec -> Interrupt
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R2: Halt holds with no run
    for (int i = 0; i < 5; i++) tick(0, 0, 1, 1, 1, 1);
    // Exhaustive sweep: every state with every input combination
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 64; c++) begin
        goto_state(s);
        tick(c[5], c[4], c[3], c[2], c[1], c[0]);
        tick(0, 1, 0, 0, 0, 0);
      end
    end
    // R8: long dwell in Exec to pass count 8 and saturate
    goto_state(3);
    for (int i = 0; i < 20; i++) tick(0, 1, 0, 0, 1, 1);
    tick(0, 0, 0, 0, 0, 0);
    // Full loops with interrupt and fail exits
    for (int k = 0; k < 4; k++) begin
      tick(0, 1, 0, 0, 0, 0);
      tick(0, 0, 0, 0, 0, 0);
      tick(0, 1, 1, 1, 0, 0);
      tick(0, 0, k[0], 1, k[1], 0);
      tick(0, 0, 0, 0, 0, 0);
    end
    // Reset in mid-operation
    do_reset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule